// File: doc/BRIEF.md
# Three-Wire Serial Word EEPROM Slave

This block behaves like a small serial nonvolatile memory of 16-bit words. A host talks to it over three wires: a select line, a bit clock and a data-in line. It answers on one data-out line that has its own output enable. The block runs on a fast system clock and oversamples the serial lines through synchronizer flops. It takes in a command as a stream of bits: a leading 1, a two-bit operation code, an address field, and, for the two write forms, a 16-bit data word. A two-bit sub-code in the upper address bits selects the four global operations.

Reads go out at once. They send one 0 placeholder bit and then the word, most significant bit first, with each bit changing on a rising edge of the serial clock. Every operation that changes the array is guarded by a programming-permit latch, and that latch is clear after reset. A programming operation starts when the select line falls after a complete command. A timed busy phase then follows, with its length given in system clocks. While the select line is high during or after that phase, the data-out line shows the state: 0 while busy and 1 once done. The word array is a simple dual-port memory. The global operations sweep it one word per clock inside the busy phase.

Top module: `serial_eeprom`

## Requirements
- R1: After reset the output enable and data-out are 0, the programming permit is clear, and no programming phase is running. The array powers up holding all zeros.
- R2: While select is high, 0 bits sampled before the first 1 are ignored. The first 1 is the start bit of the command.
- R3: Operation code 10 reads. On the serial clock edge that carries the last address bit, data-out becomes 0 (the placeholder bit). The next 16 edges each present one bit of the addressed word, from bit 15 down to bit 0. Reads work whether or not programming is permitted.
- R4: Operation code 01 is followed by 16 data bits, most significant first. With the permit set, the addressed word takes that value. No prior erase is needed.
- R5: Operation code 11 with the permit set sets the addressed word to 16'hFFFF.
- R6: Operation code 00 takes its sub-code from the top two address bits. Sub-code 11 sets the programming permit and sub-code 00 clears it, and each takes effect when the address field completes.
- R7: Under operation code 00 with the permit set, sub-code 10 sets every word to 16'hFFFF and sub-code 01 (followed by 16 data bits) writes that data word into every word.
- R8: When the permit is clear, a complete write, erase, erase-all or write-all command leaves the array unchanged.
- R9: A programming phase starts on the select falling edge that follows a complete programming command. It lasts PROG_CYCLES system clocks. While select is high, data-out shows 0 during the phase and 1 after it ends, until the next start bit is accepted.
- R10: If select falls before a command is complete, the command is dropped, the array is unchanged, and the next command needs a fresh start bit.
- R11: Serial clock edges that arrive during a programming phase are ignored, so a command sent then has no effect.
- R12: The output enable follows the synchronized select line: it is 0 while select is low and 1 while select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Select line, active high; its fall ends a command |
| sclk_i | input | 1 | Serial bit clock; data is taken on its rising edges |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out: read bits or ready/busy state |
| sdo_oe_o | output | 1 | Enable for the data-out driver |

## Verification
The bench sends commands with leading zeros and commands cut short by an early select fall. It checks that a design which failed to resync on the start bit, or which committed partial data, ends up with a corrupted word. It sends programming commands without the permit, after a disable and after an enable, and then reads the array back. This exposes a permit latch that is not cleared or that is ignored. It also sends a whole erase command during a busy phase, so a design that accepts serial edges while busy changes a word it should not touch. Every read checks the placeholder bit and the bit order, and every programming phase is polled for both the busy 0 and the ready 1.

// File: rtl/serial_eeprom_pkg.sv
package serial_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_HUNT  = 3'd0,
    ST_OPC   = 3'd1,
    ST_ADR   = 3'd2,
    ST_DAT   = 3'd3,
    ST_SEND  = 3'd4,
    ST_ARMED = 3'd5,
    ST_HOLD  = 3'd6
  } cmd_state_t;

  typedef enum logic [1:0] {
    OPC_GLOBAL = 2'b00,
    OPC_WRITE  = 2'b01,
    OPC_READ   = 2'b10,
    OPC_ERASE  = 2'b11
  } opcode_t;

  typedef enum logic [1:0] {
    SUB_LOCK   = 2'b00,
    SUB_FILL   = 2'b01,
    SUB_CLEAR  = 2'b10,
    SUB_UNLOCK = 2'b11
  } subcode_t;

endpackage

// File: rtl/se_line_sync.sv
module se_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sel_s,
  output logic sdi_s,
  output logic sclk_rise,
  output logic sel_fall
);
  logic [2:0] chain [STAGES];
  logic       sclk_q;
  logic       sel_q;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= {sel_i, sclk_i, sdi_i};
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= '0;
      else     chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      sclk_q <= chain[STAGES-1][1];
      sel_q  <= chain[STAGES-1][2];
    end
  end

  assign sel_s     = chain[STAGES-1][2];
  assign sdi_s     = chain[STAGES-1][0];
  assign sclk_rise = chain[STAGES-1][1] & ~sclk_q & chain[STAGES-1][2];
  assign sel_fall  = sel_q & ~chain[STAGES-1][2];
endmodule

// File: rtl/se_cmd_parser.sv
module se_cmd_parser
  import serial_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_s,
  input  logic              sdi_s,
  input  logic              sclk_rise,
  input  logic              sel_fall,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              permit_o,
  output logic              launch_o,
  output logic              launch_all_o,
  output logic              launch_erase_o,
  output logic              accept_o,
  output logic              rd_bit_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  cmd_state_t        st_q;
  logic [1:0]        opc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] shift_q;
  logic              permit_q;
  logic [ADDR_W-1:0] addr_nx;
  logic [1:0]        sub_nx;
  logic [DATA_W-1:0] send_src;
  logic [1:0]        sub_q;

  assign addr_nx  = {addr_q[ADDR_W-2:0], sdi_s};
  assign sub_nx   = addr_nx[ADDR_W-1 -: 2];
  assign sub_q    = addr_q[ADDR_W-1 -: 2];
  assign send_src = (cnt_q == '0) ? rdata_i : shift_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_HUNT;
      opc_q    <= '0;
      cnt_q    <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      shift_q  <= '0;
      permit_q <= 1'b0;
      launch_o <= 1'b0;
      accept_o <= 1'b0;
      rd_bit_o <= 1'b0;
    end else begin
      launch_o <= 1'b0;
      accept_o <= 1'b0;
      if (!sel_s) begin
        if (sel_fall && st_q == ST_ARMED && permit_q && !busy_i)
          launch_o <= 1'b1;
        st_q     <= ST_HUNT;
        cnt_q    <= '0;
        rd_bit_o <= 1'b0;
      end else if (sclk_rise && !busy_i) begin
        unique case (st_q)
          ST_HUNT: begin
            if (sdi_s) begin
              st_q     <= ST_OPC;
              cnt_q    <= '0;
              accept_o <= 1'b1;
            end
          end
          ST_OPC: begin
            opc_q <= {opc_q[0], sdi_s};
            if (cnt_q == CNT_W'(1)) begin
              st_q  <= ST_ADR;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_ADR: begin
            addr_q <= addr_nx;
            if (cnt_q == CNT_W'(ADDR_W - 1)) begin
              cnt_q <= '0;
              unique case (opcode_t'(opc_q))
                OPC_READ: begin
                  st_q     <= ST_SEND;
                  rd_bit_o <= 1'b0;
                end
                OPC_WRITE: st_q <= ST_DAT;
                OPC_ERASE: st_q <= ST_ARMED;
                default: begin
                  unique case (subcode_t'(sub_nx))
                    SUB_UNLOCK: begin permit_q <= 1'b1; st_q <= ST_HOLD; end
                    SUB_LOCK:   begin permit_q <= 1'b0; st_q <= ST_HOLD; end
                    SUB_CLEAR:  st_q <= ST_ARMED;
                    default:    st_q <= ST_DAT;
                  endcase
                end
              endcase
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DAT: begin
            data_q <= {data_q[DATA_W-2:0], sdi_s};
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              st_q  <= ST_ARMED;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_SEND: begin
            if (cnt_q < CNT_W'(DATA_W)) begin
              rd_bit_o <= send_src[DATA_W-1];
              shift_q  <= {send_src[DATA_W-2:0], 1'b0};
              cnt_q    <= cnt_q + 1'b1;
            end else begin
              rd_bit_o <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign addr_o         = addr_q;
  assign data_o         = data_q;
  assign permit_o       = permit_q;
  assign launch_all_o   = (opc_q == OPC_GLOBAL);
  assign launch_erase_o = (opc_q == OPC_ERASE) ||
                          (opc_q == OPC_GLOBAL && sub_q == SUB_CLEAR);

  // R11: the parser never leaves the hunt state while programming runs
  assert_idle_when_busy_R11: assert property (@(posedge clk) disable iff (rst)
    busy_i |-> st_q == ST_HUNT);
  // R3: the first bit out after the address is the 0 placeholder
  assert_read_placeholder_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SEND && cnt_q == '0) |-> !rd_bit_o);
endmodule

// File: rtl/se_prog_engine.sv
module se_prog_engine #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_i,
  input  logic              all_i,
  input  logic              erase_i,
  input  logic              permit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int SPAN  = (PROG_CYCLES > WORDS) ? PROG_CYCLES : WORDS;
  localparam int TW    = $clog2(SPAN + 1);

  if (PROG_CYCLES < WORDS) begin : g_len_check
    $error("PROG_CYCLES must cover one clock per word");
  end

  logic              busy_q;
  logic [TW-1:0]     tmr_q;
  logic              all_q;
  logic              erase_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      tmr_q   <= '0;
      all_q   <= 1'b0;
      erase_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (!busy_q) begin
      if (launch_i) begin
        busy_q  <= 1'b1;
        tmr_q   <= '0;
        all_q   <= all_i;
        erase_q <= erase_i;
        addr_q  <= addr_i;
        data_q  <= data_i;
      end
    end else if (tmr_q == TW'(PROG_CYCLES - 1)) begin
      busy_q <= 1'b0;
    end else begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign we_o    = busy_q && (all_q ? (tmr_q < TW'(WORDS)) : (tmr_q == '0));
  assign waddr_o = all_q ? tmr_q[ADDR_W-1:0] : addr_q;
  assign wdata_o = erase_q ? {DATA_W{1'b1}} : data_q;

  // R8: a phase only begins when the permit latch was set
  assert_launch_needs_permit_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(permit_i));
  // R9: the timer never runs past the configured phase length
  assert_phase_bound_R9: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> tmr_q < TW'(PROG_CYCLES));
endmodule

// File: rtl/se_word_array.sv
module se_word_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/serial_eeprom.sv
module serial_eeprom #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic              sel_s, sdi_s, sclk_rise, sel_fall;
  logic              busy, launch, launch_all, launch_erase, accept, rd_bit, permit;
  logic              we;
  logic [ADDR_W-1:0] addr, waddr;
  logic [DATA_W-1:0] data, wdata, rdata;
  logic              status_q;

  se_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sel_i(sel_i), .sclk_i(sclk_i), .sdi_i(sdi_i),
    .sel_s(sel_s), .sdi_s(sdi_s), .sclk_rise(sclk_rise), .sel_fall(sel_fall)
  );

  se_cmd_parser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst(rst), .sel_s(sel_s), .sdi_s(sdi_s), .sclk_rise(sclk_rise),
    .sel_fall(sel_fall), .busy_i(busy), .rdata_i(rdata), .addr_o(addr),
    .data_o(data), .permit_o(permit), .launch_o(launch),
    .launch_all_o(launch_all), .launch_erase_o(launch_erase),
    .accept_o(accept), .rd_bit_o(rd_bit)
  );

  se_prog_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst(rst), .launch_i(launch), .all_i(launch_all),
    .erase_i(launch_erase), .permit_i(permit), .addr_i(addr), .data_i(data),
    .busy_o(busy), .we_o(we), .waddr_o(waddr), .wdata_o(wdata)
  );

  se_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(addr), .rdata_o(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 1'b0;
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else begin
      if (launch)      status_q <= 1'b1;
      else if (accept) status_q <= 1'b0;
      sdo_oe_o <= sel_s;
      sdo_o    <= sel_s ? (status_q ? ~busy : rd_bit) : 1'b0;
    end
  end

  // R12: the driver turns off one clock after select drops
  assert_oe_off_R12: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_s) |=> !sdo_oe_o);
  // R9: while polled during a phase the output reads busy
  assert_busy_shown_R9: assert property (@(posedge clk) disable iff (rst)
    (sel_s && status_q && busy) |=> !sdo_o);
endmodule

// File: tb/sim_serial_eeprom.sv
module sim_serial_eeprom;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int WORDS = 1 << AW;
  localparam int PROG = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic last_do;
  logic [DW-1:0] model [WORDS];
  bit model_permit;

  always #2 clk = ~clk;

  serial_eeprom #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst(rst), .sel_i(sel), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  function automatic logic [DW-1:0] expect_word(input logic [AW-1:0] a);
    return model[a];
  endfunction

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b);
    sdi = b;  tick(3);
    sclk = 1'b1; tick(6);
    last_do = sdo;
    sclk = 1'b0; tick(3);
  endtask

  task automatic sel_on();
    sel = 1'b1; tick(6);
  endtask

  task automatic sel_off();
    sel = 1'b0; sclk = 1'b0; sdi = 1'b0; tick(8);
  endtask

  task automatic send_head(input logic [1:0] opc, input logic [AW-1:0] a);
    clock_bit(1'b1);
    for (int i = 1; i >= 0; i--) clock_bit(opc[i]);
    for (int i = AW-1; i >= 0; i--) clock_bit(a[i]);
  endtask

  task automatic send_data(input logic [DW-1:0] d);
    for (int i = DW-1; i >= 0; i--) clock_bit(d[i]);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string tag);
    logic [DW-1:0] got;
    sel_on();
    send_head(2'b10, a);
    check({15'd0, last_do}, 16'd0, {tag, " R3 placeholder"});
    for (int i = DW-1; i >= 0; i--) begin
      clock_bit(1'b0);
      got[i] = last_do;
    end
    sel_off();
    check(got, expect_word(a), tag);
  endtask

  task automatic finish_prog(input bit expect_run);
    sel_on();
    if (expect_run) begin
      check({15'd0, sdo}, 16'd0, "R9 busy poll");
      tick(PROG + 20);
      check({15'd0, sdo}, 16'd1, "R9 ready poll");
    end
    sel_off();
  endtask

  task automatic set_permit(input bit en);
    sel_on();
    send_head(2'b00, en ? {2'b11, 4'b0} : {2'b00, 4'b0});
    sel_off();
    model_permit = en;
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    sel_on(); send_head(2'b01, a); send_data(d); sel_off();
    if (model_permit) model[a] = d;
    finish_prog(model_permit);
  endtask

  task automatic erase_word(input logic [AW-1:0] a);
    sel_on(); send_head(2'b11, a); sel_off();
    if (model_permit) model[a] = '1;
    finish_prog(model_permit);
  endtask

  task automatic fill_all(input bit erase, input logic [DW-1:0] d);
    sel_on();
    send_head(2'b00, erase ? {2'b10, 4'b0} : {2'b01, 4'b0});
    if (!erase) send_data(d);
    sel_off();
    if (model_permit)
      for (int i = 0; i < WORDS; i++) model[i] = erase ? '1 : d;
    finish_prog(model_permit);
  endtask

  initial begin
    tick(200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    model_permit = 1'b0;
    tick(5);
    rst = 1'b0;
    tick(2);
    // R1 reset state
    check({14'd0, sdo_oe, sdo}, 16'd0, "R1 outputs after reset");
    do_read(6'd5, "R1 array zero");
    // R8: no permit after reset
    write_word(6'd5, 16'hA5A5);
    do_read(6'd5, "R8 write without permit");
    // R12 enable follows select
    sel = 1'b1; tick(6);
    check({15'd0, sdo_oe}, 16'd1, "R12 oe high");
    sel = 1'b0; tick(6);
    check({15'd0, sdo_oe}, 16'd0, "R12 oe low");
    // R6 unlock, R4 write
    set_permit(1'b1);
    write_word(6'd5, 16'hA5A5);
    do_read(6'd5, "R4 write");
    write_word(6'd63, 16'h8001);
    do_read(6'd63, "R4 write top address");
    // R5 erase
    erase_word(6'd5);
    do_read(6'd5, "R5 erase");
    // R2 leading zeros
    sel_on();
    clock_bit(1'b0); clock_bit(1'b0); clock_bit(1'b0);
    send_head(2'b01, 6'd9); send_data(16'h1234); sel_off();
    model[9] = 16'h1234;
    finish_prog(1'b1);
    do_read(6'd9, "R2 leading zeros");
    // R10 abort mid-data
    sel_on(); send_head(2'b01, 6'd9); for (int i = 0; i < 8; i++) clock_bit(1'b1); sel_off();
    do_read(6'd9, "R10 aborted write");
    // R11 command during busy is ignored
    sel_on(); send_head(2'b01, 6'd20); send_data(16'h0F0F); sel_off();
    model[20] = 16'h0F0F;
    sel_on();
    check({15'd0, sdo}, 16'd0, "R9 busy poll");
    send_head(2'b11, 6'd9);
    sel_off();
    sel_on(); tick(PROG); check({15'd0, sdo}, 16'd1, "R9 ready poll"); sel_off();
    do_read(6'd9, "R11 erase during busy");
    do_read(6'd20, "R11 preceding write");
    // R6 lock then R8
    set_permit(1'b0);
    erase_word(6'd20);
    do_read(6'd20, "R8 erase while locked");
    fill_all(1'b1, '0);
    do_read(6'd9, "R8 erase-all while locked");
    do_read(6'd20, "R6 lock read allowed R3");
    // R7 global fill and clear
    set_permit(1'b1);
    fill_all(1'b0, 16'h3C5A);
    do_read(6'd0, "R7 write-all low");
    do_read(6'd63, "R7 write-all high");
    fill_all(1'b1, '0);
    do_read(6'd31, "R7 erase-all");
    // random mix
    for (int n = 0; n < 50; n++) begin
      int kind;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      kind = $urandom_range(0, 9);
      a = AW'($urandom);
      d = DW'($urandom);
      case (kind)
        0, 1, 2: do_read(a, "R3 random read");
        3, 4:    write_word(a, d);
        5:       erase_word(a);
        6:       set_permit(1'b1);
        7:       set_permit(1'b0);
        8:       if ($urandom_range(0, 3) == 0) fill_all(1'b0, d); else do_read(a, "R3 random read");
        default: if ($urandom_range(0, 3) == 0) fill_all(1'b1, '0); else write_word(a, d);
      endcase
    end
    for (int i = 0; i < WORDS; i++) do_read(AW'(i), "R4 final sweep");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule